// File: doc/BRIEF.md
# Swizzled Scratch Address Generator

This block turns a per-lane private (scratch) byte offset into physical byte addresses. Private memory is interleaved across the 64 lanes of a wavefront at a programmable element size. Element k of lane L therefore sits next to element k of lane L+1, and every lane owns locations that no other lane touches. A request carries a scratch base address, a per-wave byte offset, a lane index, the lane's private byte offset, an access size and a 2-bit element-size code, and it is taken on a valid/ready handshake.

An access no wider than one element produces one memory request. A wider access is split into several element-sized requests, one per cycle, in ascending element order, and the last one is flagged. Each request carries an address and a byte-enable mask over the element. An access that is not aligned to its own size, or that has an unknown size code, raises a one-cycle error flag and produces no request. Software normally programs element code 1 (4-byte elements).

Top module: `swz_scratch_agu`

## Requirements
- R1: Element code 0, 1, 2 and 3 selects an element of 2, 4, 8 and 16 bytes respectively. The lane stride within an element row is `elem` bytes, and the row stride is 64·`elem` bytes.
- R2: With `elem` the element size and `off` the private offset, the first request address is `baseAddr + waveOffset + (off / elem)·64·elem + laneIdx·elem + (off % elem)`.
- R3: Bit i of `memByteEn` marks byte i counted from the start of the element. If the access is narrower than the element, the mask holds `acc` ones starting at bit `off % elem`. Otherwise it holds `elem` ones starting at bit 0.
- R4: Access size code 0..4 means 1, 2, 4, 8 and 16 bytes. An access wider than the element produces `acc/elem` requests in ascending element order, and each address is 64·`elem` above the previous one.
- R5: `memLast` is high on the final request of an access, and on no other request.
- R6: If the size code is above 4, or `off` is not a multiple of the access size, `errFlag` is high for exactly the cycle after acceptance and no request is produced.
- R7: `reqReady` is high only when no request is pending. While `memValid` is high and `memReady` is low, address, mask and last flag hold steady.
- R8: After reset, `memValid` and `errFlag` are low and `reqReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request valid |
| reqReady | output | 1 | Block can accept an access |
| baseAddr | input | ADDR_W | Scratch base address |
| waveOffset | input | ADDR_W | Per-wave byte offset |
| laneIdx | input | log2(LANES) | Lane index within the wavefront |
| privOffset | input | OFS_W | Lane's private byte offset |
| accSize | input | 3 | Access size code (0..4 = 1..16 bytes) |
| elemCode | input | 2 | Element size code (0..3 = 2..16 bytes) |
| memValid | output | 1 | Memory request valid |
| memReady | input | 1 | Memory side accepts the request |
| memAddr | output | ADDR_W | Request byte address |
| memByteEn | output | 16 | Valid bytes within the element |
| memLast | output | 1 | Final request of the access |
| errFlag | output | 1 | One-cycle pulse for a rejected access |

## Verification
The bench covers sub-element accesses at a non-zero byte inside the element. A design that drops the byte-in-element term, or that fails to shift the mask, shows the wrong address or byte lanes. It splits 8-byte and 16-byte accesses over small elements, where a wrong row stride or a wrong request count breaks the address sequence or puts the last flag on the wrong request. It uses lane 63 with the widest elements, so a lane term truncated in width shows up. It sends misaligned offsets and an illegal size code, where a faulty checker would issue requests or miss the error pulse. Random back-pressure shows whether a request drifts while it is stalled.

// File: rtl/swz_pkg.sv
package swz_pkg;
  localparam int BE_W = 16;
  typedef struct packed {
    logic load;
    logic step;
  } swz_strobe_t;
endpackage

// File: rtl/swz_ctrl.sv
module swz_ctrl
  import swz_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqBad,
  input  logic [3:0]  reqCount,
  input  logic        memReady,
  output logic        reqReady,
  output logic        memValid,
  output logic        memLast,
  output logic        errFlag,
  output swz_strobe_t strobe
);
  logic       busy;
  logic [3:0] remain;
  logic       accept;
  logic       fire;

  assign accept      = reqValid && !busy;
  assign fire        = busy && memReady;
  assign reqReady    = !busy;
  assign memValid    = busy;
  assign memLast     = busy && (remain == 4'd0);
  assign strobe.load = accept && !reqBad;
  assign strobe.step = fire && (remain != 4'd0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      remain  <= 4'd0;
      errFlag <= 1'b0;
    end else begin
      errFlag <= accept && reqBad;
      if (strobe.load) begin
        busy   <= 1'b1;
        remain <= reqCount - 4'd1;
      end else if (fire) begin
        if (remain == 4'd0) busy <= 1'b0;
        else remain <= remain - 4'd1;
      end
    end
  end

  assert_last_ends_R5: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memReady && memLast) |=> !memValid);

  assert_err_no_req_R6: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> !memValid);
endmodule

// File: rtl/swz_datapath.sv
module swz_datapath
  import swz_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 20,
  parameter int LANE_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  swz_strobe_t       strobe,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [ADDR_W-1:0] waveOffset,
  input  logic [LANE_W-1:0] laneIdx,
  input  logic [OFS_W-1:0]  privOffset,
  input  logic [2:0]        accSize,
  input  logic [1:0]        elemCode,
  output logic              reqBad,
  output logic [3:0]        reqCount,
  output logic [ADDR_W-1:0] memAddr,
  output logic [BE_W-1:0]   memByteEn
);
  localparam logic [OFS_W-1:0] OFS_ONE = OFS_W'(1);
  localparam logic [BE_W:0]    BE_ONE  = (BE_W+1)'(1);

  logic [2:0]        eShift;
  logic [4:0]        elemBytes;
  logic [4:0]        accBytes;
  logic [OFS_W-1:0]  alignMask;
  logic [OFS_W-1:0]  elemIdx;
  logic [3:0]        byteIn;
  logic [ADDR_W-1:0] addrNext;
  logic [ADDR_W-1:0] strideNext;
  logic [BE_W:0]     elemOnes;
  logic [BE_W:0]     accOnes;
  logic [BE_W-1:0]   beNext;
  logic [ADDR_W-1:0] addrReg;
  logic [ADDR_W-1:0] strideReg;
  logic [BE_W-1:0]   beReg;

  always_comb begin
    eShift     = {1'b0, elemCode} + 3'd1;
    elemBytes  = 5'd1 << eShift;
    accBytes   = (accSize > 3'd4) ? 5'd1 : (5'd1 << accSize);
    alignMask  = (OFS_ONE << accSize) - OFS_ONE;
    reqBad     = (accSize > 3'd4) || ((privOffset & alignMask) != '0);
    reqCount   = (accSize > eShift) ? (4'd1 << (accSize - eShift)) : 4'd1;
    elemIdx    = privOffset >> eShift;
    byteIn     = privOffset[3:0] & 4'(elemBytes - 5'd1);
    strideNext = ADDR_W'(1) << (LANE_W + int'(eShift));
    addrNext   = baseAddr + waveOffset
               + (ADDR_W'(elemIdx) << (LANE_W + int'(eShift)))
               + (ADDR_W'(laneIdx) << eShift)
               + ADDR_W'(byteIn);
    elemOnes   = (BE_ONE << elemBytes) - BE_ONE;
    accOnes    = (BE_ONE << accBytes) - BE_ONE;
    beNext     = (accSize >= eShift) ? elemOnes[BE_W-1:0]
                                     : (accOnes[BE_W-1:0] << byteIn);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg   <= '0;
      strideReg <= '0;
      beReg     <= '0;
    end else if (strobe.load) begin
      addrReg   <= addrNext;
      strideReg <= strideNext;
      beReg     <= beNext;
    end else if (strobe.step) begin
      addrReg <= addrReg + strideReg;
    end
  end

  assign memAddr   = addrReg;
  assign memByteEn = beReg;

  assert_stride_pow2_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> ($countones(strideReg) == 1));
endmodule

// File: rtl/swz_scratch_agu.sv
module swz_scratch_agu
  import swz_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 20,
  parameter int LANES  = 64,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [ADDR_W-1:0] waveOffset,
  input  logic [LANE_W-1:0] laneIdx,
  input  logic [OFS_W-1:0]  privOffset,
  input  logic [2:0]        accSize,
  input  logic [1:0]        elemCode,
  output logic              memValid,
  input  logic              memReady,
  output logic [ADDR_W-1:0] memAddr,
  output logic [BE_W-1:0]   memByteEn,
  output logic              memLast,
  output logic              errFlag
);
  swz_strobe_t strobe;
  logic        reqBad;
  logic [3:0]  reqCount;

  swz_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqBad(reqBad),
    .reqCount(reqCount), .memReady(memReady), .reqReady(reqReady),
    .memValid(memValid), .memLast(memLast), .errFlag(errFlag), .strobe(strobe)
  );

  swz_datapath #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .LANE_W(LANE_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .baseAddr(baseAddr),
    .waveOffset(waveOffset), .laneIdx(laneIdx), .privOffset(privOffset),
    .accSize(accSize), .elemCode(elemCode), .reqBad(reqBad),
    .reqCount(reqCount), .memAddr(memAddr), .memByteEn(memByteEn)
  );

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> (memValid && $stable(memAddr)
                                 && $stable(memByteEn) && $stable(memLast)));

  assert_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memReady && !memLast) |=>
      (memValid && ($countones(memAddr - $past(memAddr)) == 1) && $stable(memByteEn)));

  assert_be_nonzero_R3: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> (memByteEn != '0));
endmodule

// File: tb/swz_scratch_agu_tb_top.sv
module swz_scratch_agu_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] baseAddr = '0;
  logic [31:0] waveOffset = '0;
  logic [5:0]  laneIdx = '0;
  logic [19:0] privOffset = '0;
  logic [2:0]  accSize = '0;
  logic [1:0]  elemCode = '0;
  logic        memValid;
  logic        memReady = 1'b1;
  logic [31:0] memAddr;
  logic [15:0] memByteEn;
  logic        memLast;
  logic        errFlag;

  int checks = 0;
  int errors = 0;
  bit stallOn = 1'b0;
  int stallCnt = 0;
  bit prevStall = 1'b0;
  logic [31:0] prevAddr;
  logic [15:0] prevBe;
  bit finished = 1'b0;

  typedef struct {
    bit          isErr;
    logic [31:0] addr;
    logic [15:0] be;
    bit          last;
    string       tag;
  } item_t;
  item_t expQ[$];

  always #4 clk = ~clk;

  swz_scratch_agu dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .baseAddr(baseAddr), .waveOffset(waveOffset), .laneIdx(laneIdx),
    .privOffset(privOffset), .accSize(accSize), .elemCode(elemCode),
    .memValid(memValid), .memReady(memReady), .memAddr(memAddr),
    .memByteEn(memByteEn), .memLast(memLast), .errFlag(errFlag)
  );

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // driver: compute expected items from the requirements, then present the access
  task automatic sendReq(input logic [31:0] b, input logic [31:0] w, input int lane,
                         input int off, input int acc, input int ec, input string tag);
    int elem;
    int accB;
    int n;
    int bin;
    item_t it;
    elem = 2 * (1 << ec);
    if (acc > 4 || (off % (1 << acc)) != 0) begin
      it.isErr = 1'b1; it.addr = '0; it.be = '0; it.last = 1'b0; it.tag = tag;
      expQ.push_back(it);
    end else begin
      accB = 1 << acc;
      n    = (accB > elem) ? accB / elem : 1;
      bin  = (accB >= elem) ? 0 : off % elem;
      for (int k = 0; k < n; k++) begin
        it.isErr = 1'b0;
        it.addr  = b + w + 32'((off / elem + k) * 64 * elem) + 32'(lane * elem) + 32'(bin);
        it.be    = (accB >= elem) ? 16'((32'd1 << elem) - 1)
                                  : 16'(((32'd1 << accB) - 1) << bin);
        it.last  = (k == n - 1);
        it.tag   = tag;
        expQ.push_back(it);
      end
    end
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; baseAddr = b; waveOffset = w; laneIdx = 6'(lane);
    privOffset = 20'(off); accSize = 3'(acc); elemCode = 2'(ec);
    @(posedge clk);
    #1 reqValid = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while ((expQ.size() != 0 || memValid) && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    repeat (3) @(negedge clk);
  endtask

  always @(posedge clk) begin
    #1;
    stallCnt++;
    memReady = stallOn ? ((stallCnt % 3) != 0) : 1'b1;
  end

  // monitor: pop expected items as the design produces results
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (prevStall) begin
        check(memValid && memAddr == prevAddr && memByteEn == prevBe,
              "R7", "held request", memAddr, prevAddr);
      end
      prevStall = memValid && !memReady;
      prevAddr  = memAddr;
      prevBe    = memByteEn;
      if (memValid && memReady) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R6", "unexpected request", memAddr, 0);
        end else begin
          item_t e;
          e = expQ.pop_front();
          check(!e.isErr, e.tag, "request where error expected", memAddr, 0);
          check(memAddr == e.addr, e.tag, "addr", memAddr, e.addr);
          check(memByteEn == e.be, e.tag, "byteEn", memByteEn, e.be);
          check(memLast == e.last, "R5", "last", memLast, e.last);
        end
      end
      if (errFlag) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R6", "unexpected error", 1, 0);
        end else begin
          item_t e;
          e = expQ.pop_front();
          check(e.isErr, "R6", "error flag where request expected", 1, 0);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1, "R8", "reqReady after reset", reqReady, 1);
    check(memValid == 1'b0, "R8", "memValid after reset", memValid, 0);
    check(errFlag == 1'b0, "R8", "errFlag after reset", errFlag, 0);

    // R2 single dword access at dword elements
    sendReq(32'h1000, 32'h200, 5, 'h10, 2, 1, "R2");
    // R3 byte access inside a dword element
    sendReq(32'h4000, 32'h0, 9, 6, 0, 1, "R3");
    // R3 halfword at the top of a 16-byte element
    sendReq(32'h8000, 32'h40, 2, 'hE, 1, 3, "R3");
    // R1 each element code with an element-sized access
    sendReq(32'h0, 32'h0, 1, 2, 1, 0, "R1");
    sendReq(32'h0, 32'h0, 1, 8, 3, 2, "R1");
    sendReq(32'h0, 32'h0, 1, 16, 4, 3, "R1");
    // R4 64-bit access over dword elements
    sendReq(32'h2000, 32'h100, 7, 8, 3, 1, "R4");
    // R4 16-byte access over 2-byte elements: eight requests
    sendReq(32'h10000, 32'h80, 3, 'h20, 4, 0, "R4");
    // R2 lane 63 with 16-byte elements
    sendReq(32'hA0000, 32'h1000, 63, 'h30, 4, 3, "R2");
    // R6 misaligned and illegal size
    sendReq(32'h1000, 32'h0, 4, 2, 2, 1, "R6");
    sendReq(32'h1000, 32'h0, 4, 0, 5, 1, "R6");
    sendReq(32'h1000, 32'h0, 4, 4, 3, 2, "R6");
    drain();
    check(!memValid && !errFlag, "R6", "quiet after rejects", memValid, 0);

    // R7 back-pressure during splits
    stallOn = 1'b1;
    sendReq(32'h3000, 32'h10, 12, 'h40, 4, 1, "R7");
    sendReq(32'h5000, 32'h0, 30, 'h18, 3, 0, "R7");
    sendReq(32'h6000, 32'h4, 0, 3, 0, 2, "R7");
    drain();
    stallOn = 1'b0;

    check(expQ.size() == 0, "R4", "pending expected items", expQ.size(), 0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule